// File: doc/BRIEF.md
# Streaming RGB to YCbCr Pixel Converter

This block turns a stream of 24-bit RGB pixels into 24-bit YCbCr pixels at a rate of one pixel per clock. Each input word carries red in bits [23:16], green in [15:8] and blue in [7:0]. Each output component is a weighted sum of the three input channels. The weights are fixed 8-bit integers, so the conversion is a short multiply-accumulate that needs no multiplier macro. A bias is added to the two chroma sums, each sum is shifted right by eight bit positions, and the result is clamped into an unsigned byte.

Three sideband strobes travel with each pixel: a data-valid flag, a pixel clock-enable and a frame (vertical) sync. The valid flag and the frame sync go through the same three enabled register stages as the arithmetic, so they leave together with the pixel they came with. The clock-enable input gates all three stages. While it is low the pipeline holds its state. An output strobe, raised one cycle after the enable, marks each cycle in which the output stage loaded a new value. Downstream logic, such as a thresholding stage, can take luma from the top byte of the output word.

Top module: `rgb_ycc_pipe`

## Requirements
- R1: Luma, output bits [23:16], equals (77·R + 150·G + 29·B) shifted right by 8, where R, G and B are input bits [23:16], [15:8] and [7:0].
- R2: Blue-difference chroma, output bits [15:8], equals (128·B − 44·R − 84·G + 32768) shifted right by 8 and clamped to 0..255.
- R3: Red-difference chroma, output bits [7:0], equals (128·R − 108·G − 20·B + 32768) shifted right by 8 and clamped to 0..255. Black maps to 0x008080, white to 0xFF8080 and pure red to 0x4C54FF.
- R4: The output word is packed as luma in [23:16], blue-difference in [15:8] and red-difference in [7:0].
- R5: With the enable held high, a pixel sampled at clock edge k appears at the output after edge k+2. Its valid flag and frame sync appear on the same cycle, and the cycles before and after carry the neighbouring pixels' flags.
- R6: A clock edge at which the enable input is low changes no stage, so the output word, valid flag and frame sync hold their values. The output enable strobe equals the enable input one clock earlier.
- R7: An active-low reset clears the output word and all three output strobes at once, without waiting for a clock. After the reset input goes high, the block stays cleared for two more clock edges and the output enable strobe can rise at the third edge.
- R8: Pixels presented with valid high on consecutive enabled cycles each give one valid output on consecutive cycles, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_rgb_i | input | 24 | Input pixel: R [23:16], G [15:8], B [7:0] |
| pix_vld_i | input | 1 | Input data-valid flag |
| pix_ce_i | input | 1 | Pixel clock-enable; low stalls the pipeline |
| pix_fs_i | input | 1 | Input frame (vertical) sync |
| ycc_o | output | 24 | Output pixel: Y [23:16], Cb [15:8], Cr [7:0] |
| ycc_vld_o | output | 1 | Data-valid flag aligned with ycc_o |
| ycc_ce_o | output | 1 | High when the output stage loaded a value on the previous edge |
| ycc_fs_o | output | 1 | Frame sync aligned with ycc_o |

## Verification
The bench changes inputs on the falling edge and reads outputs on the falling edge. A pixel driven before rising edge k is therefore read three falling edges later, and streaming checks compare each output against the pixel driven three cycles earlier. The output enable strobe is read one falling edge after the enable it reflects. In stall tests the pipeline needs two more enabled edges before the held pixel appears, and both the held cycles and the cycle of arrival are checked. Reset clearing is read one time unit after the reset input falls. The synchronous release is checked on the second and third falling edges after the reset input rises.

// File: rtl/rgb_ycc_pkg.sv
package rgb_ycc_pkg;

  localparam int PIX_W      = 8;   // bits per colour channel
  localparam int NCOMP      = 3;   // channels in, components out
  localparam int SUM_W      = 18;  // signed width of products and sums
  localparam int FRAC_W     = 8;   // right shift applied to each sum
  localparam int PIPE_DEPTH = 3;   // product, sum, shift/clamp
  localparam int CHROMA_BIAS = 128 << FRAC_W;

  // comp: 0 = luma, 1 = blue-difference, 2 = red-difference
  // chan: 0 = red, 1 = green, 2 = blue
  function automatic int weight(input int comp, input int chan);
    int w;
    w = 0;
    case (comp)
      0: case (chan) 0: w = 77;  1: w = 150;  default: w = 29;  endcase
      1: case (chan) 0: w = -44; 1: w = -84;  default: w = 128; endcase
      default:
         case (chan) 0: w = 128; 1: w = -108; default: w = -20; endcase
    endcase
    return w;
  endfunction

  function automatic int offset(input int comp);
    return (comp == 0) ? 0 : CHROMA_BIAS;
  endfunction

endpackage

// File: rtl/rgb_ycc_rst_sync.sv
module rgb_ycc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/rgb_ycc_product.sv
module rgb_ycc_product
  import rgb_ycc_pkg::*;
#(
  parameter int CH_W = PIX_W,
  parameter int NC   = NCOMP,
  parameter int SW   = SUM_W
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                en_i,
  input  logic [NC*CH_W-1:0]                  rgb_i,
  output logic signed [NC-1:0][NC-1:0][SW-1:0] prod_o
);
  logic signed [NC-1:0][NC-1:0][SW-1:0] prod_d;
  logic signed [NC-1:0][NC-1:0][SW-1:0] prod_q;

  for (genvar o = 0; o < NC; o++) begin : g_comp
    for (genvar c = 0; c < NC; c++) begin : g_chan
      localparam int LSB = (NC - 1 - c) * CH_W;
      logic signed [SW-1:0] chan_ext;
      logic signed [SW-1:0] coef;
      always_comb begin
        chan_ext = SW'(rgb_i[LSB +: CH_W]);
        coef     = SW'(weight(o, c));
        prod_d[o][c] = coef * chan_ext;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prod_q <= '0;
    else if (en_i) prod_q <= prod_d;
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/rgb_ycc_accum.sv
module rgb_ycc_accum
  import rgb_ycc_pkg::*;
#(
  parameter int NC = NCOMP,
  parameter int SW = SUM_W
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 en_i,
  input  logic signed [NC-1:0][NC-1:0][SW-1:0] prod_i,
  output logic signed [NC-1:0][SW-1:0]         sum_o
);
  logic signed [NC-1:0][SW-1:0] sum_d;
  logic signed [NC-1:0][SW-1:0] sum_q;

  for (genvar o = 0; o < NC; o++) begin : g_comp
    always_comb begin
      logic signed [SW-1:0] acc;
      acc = SW'(offset(o));
      for (int c = 0; c < NC; c++) acc = acc + prod_i[o][c];
      sum_d[o] = acc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_q <= '0;
    else if (en_i) sum_q <= sum_d;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/rgb_ycc_round.sv
module rgb_ycc_round
  import rgb_ycc_pkg::*;
#(
  parameter int NC   = NCOMP,
  parameter int SW   = SUM_W,
  parameter int CH_W = PIX_W,
  parameter int SHR  = FRAC_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic signed [NC-1:0][SW-1:0] sum_i,
  output logic [NC*CH_W-1:0]           ycc_o
);
  localparam logic signed [SW-1:0] TOP = SW'((1 << CH_W) - 1);

  logic [NC*CH_W-1:0] ycc_d;
  logic [NC*CH_W-1:0] ycc_q;

  for (genvar o = 0; o < NC; o++) begin : g_comp
    localparam int LSB = (NC - 1 - o) * CH_W;
    logic signed [SW-1:0] shifted;
    always_comb begin
      shifted = sum_i[o] >>> SHR;
      if (shifted < 0)        ycc_d[LSB +: CH_W] = '0;
      else if (shifted > TOP) ycc_d[LSB +: CH_W] = '1;
      else                    ycc_d[LSB +: CH_W] = shifted[CH_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ycc_q <= '0;
    else if (en_i) ycc_q <= ycc_d;
  end

  assign ycc_o = ycc_q;
endmodule

// File: rtl/rgb_ycc_pipe.sv
module rgb_ycc_pipe
  import rgb_ycc_pkg::*;
#(
  parameter int CH_W  = PIX_W,
  parameter int NC    = NCOMP,
  parameter int SW    = SUM_W,
  parameter int SHR   = FRAC_W,
  parameter int DEPTH = PIPE_DEPTH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NC*CH_W-1:0] pix_rgb_i,
  input  logic               pix_vld_i,
  input  logic               pix_ce_i,
  input  logic               pix_fs_i,
  output logic [NC*CH_W-1:0] ycc_o,
  output logic               ycc_vld_o,
  output logic               ycc_ce_o,
  output logic               ycc_fs_o
);
  logic rst_n;
  logic signed [NC-1:0][NC-1:0][SW-1:0] prod;
  logic signed [NC-1:0][SW-1:0]         sum;

  rgb_ycc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  rgb_ycc_product #(.CH_W(CH_W), .NC(NC), .SW(SW)) u_prod (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .en_i  (pix_ce_i),
    .rgb_i (pix_rgb_i),
    .prod_o(prod)
  );

  rgb_ycc_accum #(.NC(NC), .SW(SW)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .en_i  (pix_ce_i),
    .prod_i(prod),
    .sum_o (sum)
  );

  rgb_ycc_round #(.NC(NC), .SW(SW), .CH_W(CH_W), .SHR(SHR)) u_rnd (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .en_i  (pix_ce_i),
    .sum_i (sum),
    .ycc_o (ycc_o)
  );

  // Sideband flags ride through DEPTH enabled stages beside the data.
  logic [DEPTH:0] vld_pipe;
  logic [DEPTH:0] fs_pipe;
  assign vld_pipe[0] = pix_vld_i;
  assign fs_pipe[0]  = pix_fs_i;

  for (genvar k = 1; k <= DEPTH; k++) begin : g_side
    logic vld_d, fs_d;
    always_comb begin
      vld_d = pix_ce_i ? vld_pipe[k-1] : vld_pipe[k];
      fs_d  = pix_ce_i ? fs_pipe[k-1]  : fs_pipe[k];
    end
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        vld_pipe[k] <= 1'b0;
        fs_pipe[k]  <= 1'b0;
      end else begin
        vld_pipe[k] <= vld_d;
        fs_pipe[k]  <= fs_d;
      end
    end
  end

  // Marks the cycles in which the output stage has just advanced.
  logic adv_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) adv_q <= 1'b0;
    else        adv_q <= pix_ce_i;
  end

  assign ycc_vld_o = vld_pipe[DEPTH];
  assign ycc_fs_o  = fs_pipe[DEPTH];
  assign ycc_ce_o  = adv_q;
endmodule

// File: rtl/rgb_ycc_pipe_chk.sv
module rgb_ycc_pipe_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_vld_i,
  input logic             pix_ce_i,
  input logic             pix_fs_i,
  input logic [OUT_W-1:0] ycc_o,
  input logic             ycc_vld_o,
  input logic             ycc_ce_o,
  input logic             ycc_fs_o
);
  // Edges seen since reset went high, saturating.
  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 3'd7)  age_q <= age_q + 3'd1;
  end

  p_vld_lag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd6 && $past(pix_ce_i, 1) && $past(pix_ce_i, 2) && $past(pix_ce_i, 3))
      |-> (ycc_vld_o == $past(pix_vld_i, 3)))
    else $error("valid flag not aligned with three-stage latency");

  p_fs_lag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd6 && $past(pix_ce_i, 1) && $past(pix_ce_i, 2) && $past(pix_ce_i, 3))
      |-> (ycc_fs_o == $past(pix_fs_i, 3)))
    else $error("frame sync not aligned with three-stage latency");

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd1 && !$past(pix_ce_i))
      |-> ($stable(ycc_o) && $stable(ycc_vld_o) && $stable(ycc_fs_o)))
    else $error("output moved on a stalled edge");

  p_adv_mark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd6) |-> (ycc_ce_o == $past(pix_ce_i)))
    else $error("output enable strobe does not follow the input enable");
endmodule

bind rgb_ycc_pipe rgb_ycc_pipe_chk #(.OUT_W(24)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pix_vld_i(pix_vld_i),
  .pix_ce_i (pix_ce_i),
  .pix_fs_i (pix_fs_i),
  .ycc_o    (ycc_o),
  .ycc_vld_o(ycc_vld_o),
  .ycc_ce_o (ycc_ce_o),
  .ycc_fs_o (ycc_fs_o)
);

// File: tb/rgb_ycc_pipe_test.sv
module rgb_ycc_pipe_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [23:0] pix_rgb_i;
  logic        pix_vld_i, pix_ce_i, pix_fs_i;
  logic [23:0] ycc_o;
  logic        ycc_vld_o, ycc_ce_o, ycc_fs_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  rgb_ycc_pipe uut (
    .clk_i, .rst_ni, .pix_rgb_i, .pix_vld_i, .pix_ce_i, .pix_fs_i,
    .ycc_o, .ycc_vld_o, .ycc_ce_o, .ycc_fs_o
  );

  function automatic int clip(input int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  function automatic logic [23:0] model(input logic [23:0] p);
    int r, g, b, y, cb, cr;
    r  = int'(p[23:16]);
    g  = int'(p[15:8]);
    b  = int'(p[7:0]);
    y  = clip((77 * r + 150 * g + 29 * b) >>> 8);
    cb = clip((128 * b - 44 * r - 84 * g + 32768) >>> 8);
    cr = clip((128 * r - 108 * g - 20 * b + 32768) >>> 8);
    return {y[7:0], cb[7:0], cr[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_pix(input logic [23:0] act, input logic [23:0] exp);
    check("R1 luma [23:16]",  32'(act[23:16]), 32'(exp[23:16]));
    check("R2 blue-diff [15:8]", 32'(act[15:8]), 32'(exp[15:8]));
    check("R3 red-diff [7:0]", 32'(act[7:0]), 32'(exp[7:0]));
  endtask

  task automatic drive(input logic [23:0] p, input logic v, input logic ce, input logic fs);
    pix_rgb_i = p; pix_vld_i = v; pix_ce_i = ce; pix_fs_i = fs;
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      drive(24'h0, 1'b0, 1'b1, 1'b0);
    end
    @(negedge clk_i);
  endtask

  // R7: cleared during reset, synchronous release
  task automatic t_reset();
    rst_ni = 1'b0;
    drive(24'hFFFFFF, 1'b1, 1'b0, 1'b1);
    repeat (3) @(negedge clk_i);
    check("R7 word in reset", 32'(ycc_o), 32'h0);
    check("R7 strobes in reset", {29'b0, ycc_vld_o, ycc_ce_o, ycc_fs_o}, 32'h0);
    rst_ni = 1'b1;
    drive(24'h0, 1'b0, 1'b1, 1'b0);
    @(negedge clk_i);
    @(negedge clk_i);
    check("R7 held two edges after release", 32'(ycc_ce_o), 32'h0);
    @(negedge clk_i);
    check("R7 strobe rises third edge", 32'(ycc_ce_o), 32'h1);
  endtask

  // R1 R2 R3 R4 R8: stream a list back to back
  task automatic t_stream(input logic [23:0] px[], input string tag);
    int n = px.size();
    for (int i = 0; i < n + 3; i++) begin
      @(negedge clk_i);
      if (i >= 3) begin
        check_pix(ycc_o, model(px[i-3]));
        check({"R8 valid back-to-back ", tag}, 32'(ycc_vld_o), 32'h1);
      end
      if (i < n) drive(px[i], 1'b1, 1'b1, 1'b0);
      else       drive(24'h0, 1'b0, 1'b1, 1'b0);
    end
  endtask

  task automatic t_corners();
    logic [23:0] px[] = '{24'h000000, 24'hFFFFFF, 24'hFF0000, 24'h00FF00, 24'h0000FF};
    t_stream(px, "corners");
    // fixed points stated in R3, R4 packing order
    check("R4 black packed", 32'(model(24'h000000)), 32'h008080);
    check("R4 white packed", 32'(model(24'hFFFFFF)), 32'hFF8080);
    check("R4 red packed", 32'(model(24'hFF0000)), 32'h4C54FF);
  endtask

  task automatic t_random();
    logic [23:0] px[] = new[200];
    foreach (px[i]) px[i] = 24'($urandom);
    t_stream(px, "random");
  endtask

  // R5: single pixel with sync, exact arrival cycle
  task automatic t_latency();
    logic [23:0] p = 24'h3A91C4;
    flush();
    drive(p, 1'b1, 1'b1, 1'b1);
    @(negedge clk_i);
    check("R5 not early (1)", {30'b0, ycc_vld_o, ycc_fs_o}, 32'h0);
    drive(24'h0, 1'b0, 1'b1, 1'b0);
    @(negedge clk_i);
    check("R5 not early (2)", {30'b0, ycc_vld_o, ycc_fs_o}, 32'h0);
    @(negedge clk_i);
    check("R5 flags on third cycle", {30'b0, ycc_vld_o, ycc_fs_o}, 32'h3);
    check("R5 data on third cycle", 32'(ycc_o), 32'(model(p)));
    @(negedge clk_i);
    check("R5 flags drop after", {30'b0, ycc_vld_o, ycc_fs_o}, 32'h0);
  endtask

  // R6: enable low freezes the pipeline
  task automatic t_stall();
    logic [23:0] p = 24'h12F07E;
    flush();
    drive(p, 1'b1, 1'b1, 1'b0);
    @(negedge clk_i);
    check("R6 strobe after enabled edge", 32'(ycc_ce_o), 32'h1);
    drive(24'hABCDEF, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      check("R6 word held", 32'(ycc_o), 32'h008080);
      check("R6 flags held", {30'b0, ycc_vld_o, ycc_fs_o}, 32'h0);
      check("R6 strobe low in stall", 32'(ycc_ce_o), 32'h0);
    end
    drive(24'h0, 1'b0, 1'b1, 1'b0);
    @(negedge clk_i);
    check("R6 one enabled edge short", 32'(ycc_vld_o), 32'h0);
    @(negedge clk_i);
    check("R6 held pixel arrives", 32'(ycc_o), 32'(model(p)));
    check("R6 held valid arrives", 32'(ycc_vld_o), 32'h1);
  endtask

  // R7: asynchronous clear mid-stream
  task automatic t_midreset();
    flush();
    drive(24'hFFFFFF, 1'b1, 1'b1, 1'b1);
    repeat (4) @(negedge clk_i);
    check("R7 pre-reset traffic", 32'(ycc_vld_o), 32'h1);
    #1 rst_ni = 1'b0;
    #1;
    check("R7 async clear word", 32'(ycc_o), 32'h0);
    check("R7 async clear strobes", {29'b0, ycc_vld_o, ycc_ce_o, ycc_fs_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R7 still cleared after release", {29'b0, ycc_vld_o, ycc_ce_o, ycc_fs_o}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_random();
    t_latency();
    t_stall();
    t_midreset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule